// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits on the peripheral side of a byte-wide parallel host bus and gives a local microprocessor read and write access to a small internal register file. A static strap input chooses between two bus styles. In the first style, a positive address-latch pulse captures the address, and separate active-low read and write strobes carry the access. An active-low wait-style handshake holds the cycle open until the data is ready. In the second style, an active-low address strobe captures the address, a direction line (high for read) sets the transfer type, and an active-low data strobe carries the access. The same handshake pin then acts as an active-low acknowledge that ends the cycle.

The register port takes a programmable number of wait cycles (0 to 7) before read data is valid or a write commits. The handshake pin shows this delay in both styles. The data bus is split into input, output and output-enable signals. The bus is driven only while a selected read strobe is active. Register addresses 0 to 15 are implemented; any other address reads as zero and ignores writes.

Top module: `host_bus_if`

## Requirements
- R1: `bus_style_i`=0 selects strobe style A: `cyc_start_i` active high, `rd_strb_ni` is the active-low read strobe, and `wr_dir_i` is the active-low write strobe. `bus_style_i`=1 selects style B: `cyc_start_i` active low, `rd_strb_ni` is the active-low data strobe, and `wr_dir_i` is the direction (1 read, 0 write).
- R2: The address is captured on the first clock edge where `cyc_start_i` becomes active. Later changes of `addr_i` do not affect that access.
- R3: In style A, `hs_no` goes low in the same cycle that a selected strobe becomes active. It returns high N+1 clock edges after the first edge that sees the strobe, where N is `wait_cycles_i`.
- R4: In style B, `hs_no` goes low N+1 clock edges after the first edge that sees the selected data strobe. It stays low until the strobe or chip select is removed, then goes high in the same cycle.
- R5: A write stores `data_i` exactly once, at the edge where the handshake completes, into the register at the latched address. The register at address k (k<16) is read back at address k.
- R6: `data_oe_o` is high only while `sel_ni` is low and a read strobe is active. The read data on `data_o` is valid when the handshake completes and stays stable until the strobe is removed.
- R7: Addresses 16 to 511 read as 0x00, and writes to them change no implemented register.
- R8: An access whose strobe is removed before the handshake completes commits no write.
- R9: While `sel_ni` is high, or no strobe is active, `hs_no` is high, `data_oe_o` is low, and no register is written.
- R10: After reset, `hs_no` is high, `data_oe_o` is low, `data_o` is 0x00, and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_style_i | input | 1 | Bus style strap (0 style A, 1 style B) |
| sel_ni | input | 1 | Active-low chip select |
| cyc_start_i | input | 1 | Address latch (A, high) / address strobe (B, low) |
| rd_strb_ni | input | 1 | Read strobe (A) / data strobe (B), active low |
| wr_dir_i | input | 1 | Write strobe, active low (A) / direction, 1 = read (B) |
| addr_i | input | 9 | Address bus |
| wait_cycles_i | input | 3 | Register port wait cycles |
| data_i | input | 8 | Data bus, host to block |
| data_o | output | 8 | Data bus, block to host |
| data_oe_o | output | 1 | Data bus output enable |
| hs_no | output | 1 | Wait (A) / acknowledge (B) handshake, active low |

## Verification
The block samples a strobe at the first clock edge. After that edge, the handshake completes after N+1 more edges. With inputs driven at a falling edge, completion is therefore seen at the N+2nd falling edge. The bench counts falling edges from the strobe to completion and compares the count with N+2 for several wait settings in both styles. Combinational effects are sampled 1 ns after the input changes: the style-A wait going low, the handshake release, and the output-enable response. Read values and the stability of held data are sampled at falling edges once the handshake has completed.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } hbi_state_e;

  typedef struct packed {
    logic sel;
    logic strobe;
    logic is_read;
    logic latch;
  } hbi_bus_t;
endpackage

// File: rtl/hbi_strobe_norm.sv
module hbi_strobe_norm
  import hbi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bus_style_i,
  input  logic     sel_ni,
  input  logic     cyc_start_i,
  input  logic     rd_strb_ni,
  input  logic     wr_dir_i,
  output hbi_bus_t bus_o
);
  logic start_act, start_q;

  // style B address strobe is active low
  assign start_act = bus_style_i ? ~cyc_start_i : cyc_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_act;
  end

  always_comb begin
    bus_o.sel   = ~sel_ni;
    bus_o.latch = start_act & ~start_q;
    if (bus_style_i) begin
      bus_o.strobe  = ~rd_strb_ni;
      bus_o.is_read = wr_dir_i;
    end else begin
      bus_o.strobe  = ~rd_strb_ni | ~wr_dir_i;
      bus_o.is_read = ~rd_strb_ni;
    end
  end
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_style_i,
  input  hbi_bus_t          bus_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  output logic              start_o,
  output logic              commit_o,
  output logic              dir_rd_o,
  output logic              hs_no
);
  hbi_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              act;

  assign act = bus_i.sel & bus_i.strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      dir_rd_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (act) begin
          state_q  <= ST_WAIT;
          cnt_q    <= wait_cycles_i;
          dir_rd_o <= bus_i.is_read;
        end
        ST_WAIT: begin
          if (!act)            state_q <= ST_IDLE;
          else if (cnt_q == 0) state_q <= ST_DONE;
          else                 cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: if (!act) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o  = (state_q == ST_IDLE) & act;
  assign commit_o = (state_q == ST_WAIT) & act & (cnt_q == 0);

  // A: low = wait; B: low = acknowledge
  always_comb begin
    if (bus_style_i) hs_no = ~(act & (state_q == ST_DONE));
    else             hs_no = ~(act & (state_q != ST_DONE));
  end
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              hit;

  assign hit = (32'(addr_i) < NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[i] <= '0;
      else if (we_i && hit && 32'(addr_i) == i) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit && 32'(addr_i) == i) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int WAIT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_style_i,
  input  logic              sel_ni,
  input  logic              cyc_start_i,
  input  logic              rd_strb_ni,
  input  logic              wr_dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              hs_no
);
  hbi_bus_t          bus;
  logic              start, commit, dir_rd, wr_commit;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rf_rdata, rdata_q;

  hbi_strobe_norm u_norm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_style_i (bus_style_i),
    .sel_ni      (sel_ni),
    .cyc_start_i (cyc_start_i),
    .rd_strb_ni  (rd_strb_ni),
    .wr_dir_i    (wr_dir_i),
    .bus_o       (bus)
  );

  hbi_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_style_i   (bus_style_i),
    .bus_i         (bus),
    .wait_cycles_i (wait_cycles_i),
    .start_o       (start),
    .commit_o      (commit),
    .dir_rd_o      (dir_rd),
    .hs_no         (hs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (bus.latch) addr_q <= addr_i;
  end

  assign wr_commit = commit & ~dir_rd;

  hbi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_commit),
    .addr_i  (addr_q),
    .wdata_i (data_i),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (commit && dir_rd) rdata_q <= rf_rdata;
    else if (start)            rdata_q <= '0;
  end

  assign data_o    = rdata_q;
  assign data_oe_o = bus.sel & bus.strobe & bus.is_read;
endmodule

// File: rtl/host_bus_if_chk.sv
module host_bus_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_style_i,
  input logic              sel_ni,
  input logic              rd_strb_ni,
  input logic              wr_dir_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              hs_no,
  input logic              wr_commit
);
  logic strb, rd_strb;
  assign strb    = bus_style_i ? ~rd_strb_ni : (~rd_strb_ni | ~wr_dir_i);
  assign rd_strb = bus_style_i ? (~rd_strb_ni & wr_dir_i) : ~rd_strb_ni;

  assert_idle_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni || !strb) |-> hs_no);

  assert_no_write_unsel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit |-> (!sel_ni && strb));

  assert_oe_read_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!sel_ni && rd_strb));

  assert_write_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit |=> !wr_commit);

  assert_ack_hold_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_style_i && !hs_no && $past(!hs_no) && rd_strb && $past(rd_strb)) |-> $stable(data_o));

  assert_ack_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_style_i && !hs_no && !sel_ni && strb && $past(bus_style_i)) |=>
      (hs_no == (sel_ni || !strb)));
endmodule

bind host_bus_if host_bus_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_style_i (bus_style_i),
  .sel_ni      (sel_ni),
  .rd_strb_ni  (rd_strb_ni),
  .wr_dir_i    (wr_dir_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .hs_no       (hs_no),
  .wr_commit   (wr_commit)
);

// File: tb/host_bus_if_bench.sv
module host_bus_if_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_style_i = 1'b0;
  logic       sel_ni = 1'b1;
  logic       cyc_start_i = 1'b0;
  logic       rd_strb_ni = 1'b1;
  logic       wr_dir_i = 1'b1;
  logic [8:0] addr_i = '0;
  logic [2:0] wait_cycles_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic       hs_no;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  host_bus_if u_host_bus_if (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_style_i(bus_style_i), .sel_ni(sel_ni),
    .cyc_start_i(cyc_start_i), .rd_strb_ni(rd_strb_ni), .wr_dir_i(wr_dir_i),
    .addr_i(addr_i), .wait_cycles_i(wait_cycles_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .hs_no(hs_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_style(input bit b);
    @(negedge clk_i);
    bus_style_i = b;
    cyc_start_i = b;   // inactive level for either style
    rd_strb_ni  = 1'b1;
    wr_dir_i    = 1'b1;
    sel_ni      = 1'b1;
  endtask

  // generic access; abort_after>0 drops strobe after that many falling edges
  task automatic access(input bit is_rd, input logic [8:0] a, input logic [7:0] wd,
                        input logic [2:0] nw, input int hold, input int abort_after,
                        output logic [7:0] rd);
    int cyc = 0;
    bit b = bus_style_i;
    logic [7:0] first;
    @(negedge clk_i);
    wait_cycles_i = nw;
    sel_ni = 1'b0;
    addr_i = a;
    if (b) begin cyc_start_i = 1'b0; wr_dir_i = is_rd; end
    else   cyc_start_i = 1'b1;
    @(negedge clk_i);
    if (!b) cyc_start_i = 1'b0;
    addr_i = a ^ 9'h1AA;  // R2: address moves after latch
    data_i = wd;
    if (b) rd_strb_ni = 1'b0;
    else if (is_rd) rd_strb_ni = 1'b0;
    else wr_dir_i = 1'b0;
    #1;
    if (!b) chk("R3 wait low on strobe", hs_no, 0);
    else    chk("R4 ack high on strobe", hs_no, 1);
    if (is_rd) chk("R6 oe on read strobe", data_oe_o, 1);
    else       chk("R6 oe off on write", data_oe_o, 0);
    if (abort_after > 0) begin
      repeat (abort_after) @(negedge clk_i);
      chk("R8 not complete before abort", hs_no, b ? 1 : 0);
    end else begin
      do begin
        @(negedge clk_i);
        cyc++;
      end while ((b ? hs_no : !hs_no) && cyc < 20);
      chk(b ? "R4 ack latency" : "R3 wait latency", cyc, int'(nw) + 2);
      first = data_o;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk_i);
        chk("R6 data held", data_o, first);
        chk(b ? "R4 ack held" : "R3 ready held", hs_no, b ? 0 : 1);
      end
    end
    rd = data_o;
    rd_strb_ni = 1'b1;
    if (!b) wr_dir_i = 1'b1;
    #1;
    chk("R9 handshake idle after strobe", hs_no, 1);
    chk("R9 oe off after strobe", data_oe_o, 0);
    @(negedge clk_i);
    sel_ni = 1'b1;
    if (b) begin cyc_start_i = 1'b1; wr_dir_i = 1'b1; end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d, input logic [2:0] nw);
    logic [7:0] dummy;
    access(1'b0, a, d, nw, 0, 0, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [2:0] nw,
                        input logic [7:0] exp);
    logic [7:0] v;
    access(1'b1, a, 8'h00, nw, 0, 0, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk("R10 handshake after reset", hs_no, 1);
    chk("R10 oe after reset", data_oe_o, 0);
    chk("R10 data after reset", data_o, 0);
    rd_chk("R10 reg7 reset value", 9'h007, 3'd0, 8'h00);
  endtask

  task automatic t_style_a;
    set_style(1'b0);
    wr(9'h003, 8'hA5, 3'd0);
    rd_chk("R5 style A readback r3", 9'h003, 3'd0, 8'hA5);
    wr(9'h00F, 8'h3C, 3'd7);
    rd_chk("R5 style A readback r15", 9'h00F, 3'd4, 8'h3C);
    rd_chk("R2 latched address r3", 9'h003, 3'd1, 8'hA5);
  endtask

  task automatic t_style_b;
    logic [7:0] v;
    set_style(1'b1);
    wr(9'h000, 8'h5A, 3'd2);
    rd_chk("R1 style B readback r0", 9'h000, 3'd0, 8'h5A);
    rd_chk("R1 style B reads style A data", 9'h003, 3'd6, 8'hA5);
    access(1'b1, 9'h00F, 8'h00, 3'd3, 4, 0, v);
    chk("R6 held read value", v, 8'h3C);
  endtask

  task automatic t_unimpl;
    set_style(1'b0);
    wr(9'h100, 8'hFF, 3'd1);
    rd_chk("R7 high address reads zero", 9'h100, 3'd0, 8'h00);
    rd_chk("R7 no alias into r0", 9'h000, 3'd0, 8'h5A);
    set_style(1'b1);
    wr(9'h010, 8'h77, 3'd0);
    rd_chk("R7 addr 16 reads zero", 9'h010, 3'd0, 8'h00);
  endtask

  task automatic t_deselect;
    set_style(1'b0);
    @(negedge clk_i);
    addr_i = 9'h000; cyc_start_i = 1'b1;
    @(negedge clk_i);
    cyc_start_i = 1'b0; data_i = 8'hEE; wait_cycles_i = 3'd0; wr_dir_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk("R9 deselected write hs", hs_no, 1);
    end
    wr_dir_i = 1'b1; rd_strb_ni = 1'b0;
    #1 chk("R9 deselected read oe", data_oe_o, 0);
    @(negedge clk_i);
    rd_strb_ni = 1'b1;
    rd_chk("R9 deselected write ignored", 9'h000, 3'd0, 8'h5A);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    set_style(1'b0);
    access(1'b0, 9'h003, 8'h11, 3'd5, 0, 2, v);
    rd_chk("R8 style A abort no write", 9'h003, 3'd0, 8'hA5);
    set_style(1'b1);
    access(1'b0, 9'h00F, 8'h22, 3'd4, 0, 3, v);
    rd_chk("R8 style B abort no write", 9'h00F, 3'd0, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_style_a;
    t_style_b;
    t_unimpl;
    t_deselect;
    t_abort;
    repeat (3) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule